// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block sits between the unit that ranks interrupt requests and the CPU sequencer. Every cycle it decides whether the highest pending request may be taken. Three conditions can hold a request back. The first is a fixed blackout after any instruction that rewrites the interrupt mask. The second is a delayed commit of the new mask bit. The third is the state of the block-move engine. A byte-mode move holds off every request until the move finishes. A word-mode move lets a request through only at a break between transfer units.

The sequencer presents the pending requests and the end-of-instruction pulse for mask updates, together with the new mask value. The block-move engine supplies its status. The gate answers with a registered single-cycle take strobe. Alongside the strobe it gives a flag saying whether the taken request was the non-maskable one. A second flag says whether the saved return point is the instruction after the block move. The gate also drives the mask value now in force. Requests are never dropped here: the source keeps a request asserted until it sees a take.

Top module: `irq_accept_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `irq_take`, `irq_take_nmi` and `resume_next` are 0 and `mask_eff` is 1 (masked). The blackout is clear after reset, so a request can be taken in the first cycle after reset.
- R2: The inputs are sampled in a cycle. If that cycle is eligible, `irq_take` is 1 in the next cycle, for one cycle only. A cycle is never eligible when `irq_take` is already 1, so two strobes never come back to back.
- R3: A cycle is blocked when `mask_upd` is 1 in it, and also in the two cycles after a pulse, which gives three cycles in all. This applies to the non-maskable request as well. As a result, the instruction that follows the mask update always runs first.
- R4: A new `mask_upd` pulse during the blackout restarts the window, so the block covers the new pulse cycle and the two cycles after it.
- R5: A `mask_new` value sampled with `mask_upd` in cycle t appears on `mask_eff` from cycle t+2. Up to that point the previous value decides masking, and `mask_eff` changes at no other time.
- R6: The maskable request (`irq_pend`) is eligible only while `mask_eff` is 0. The non-maskable request (`nmi_pend`) ignores `mask_eff`.
- R7: A byte-mode move (`mv_active`=1, `mv_word`=0) makes every cycle ineligible, including for the non-maskable request.
- R8: During a word-mode move (`mv_active`=1, `mv_word`=1), only cycles with `mv_break`=1 are eligible. A take that comes from such a cycle sets `resume_next`=1, meaning the return point is the next instruction. Every other take leaves `resume_next` at 0.
- R9: If both requests are eligible in the same cycle, the non-maskable one wins and `irq_take_nmi`=1. When only the maskable request is taken, `irq_take_nmi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | Maskable request pending, held until taken |
| nmi_pend | input | 1 | Non-maskable request pending, held until taken |
| mask_upd | input | 1 | One-cycle pulse at the end of a mask-writing instruction |
| mask_new | input | 1 | Mask value written by that instruction (1 = masked) |
| mv_active | input | 1 | Block move in progress |
| mv_word | input | 1 | Move mode: 1 = word, 0 = byte |
| mv_break | input | 1 | Pulse at a boundary between transfer units |
| irq_take | output | 1 | Registered single-cycle accept strobe |
| irq_take_nmi | output | 1 | The accepted request is the non-maskable one |
| resume_next | output | 1 | Accepted at a word-move break; return to the next instruction |
| mask_eff | output | 1 | Mask value currently in force |

## Verification
The assertions assume that `mask_upd` is held low during reset and that `mv_break` is only raised while a word-mode move is active. Under those assumptions, every take can be traced back to the input values of the cycle before it. The random stimulus keeps to this. It raises `mv_break` only inside word moves. It keeps each request high until a take is observed and only then lets it drop. Its mask pulses are frequent enough that some of them fall inside an open blackout.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned BLACKOUT_DEF   = 3;
  localparam int unsigned MASK_DELAY_DEF = 2;

  typedef struct packed {
    logic vld;
    logic val;
  } mask_stage_t;

  typedef struct packed {
    logic nmi;
    logic mskd;
    logic at_break;
  } take_t;
endpackage

// File: rtl/irq_blackout.sv
module irq_blackout #(
  parameter int unsigned BLACKOUT = 3,
  localparam int unsigned CW = (BLACKOUT > 1) ? $clog2(BLACKOUT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  output logic blocked
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (upd)
      cnt_q <= CW'(BLACKOUT - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign blocked = upd | (cnt_q != '0);
endmodule

// File: rtl/irq_mask_commit.sv
module irq_mask_commit
  import irq_gate_pkg::*;
#(
  parameter int unsigned MASK_DELAY = 2,
  localparam int unsigned NSTG = (MASK_DELAY > 1) ? MASK_DELAY - 1 : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic val,
  output logic mask_q
);
  mask_stage_t stg_q [NSTG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTG; i++) stg_q[i] <= '0;
      mask_q <= 1'b1;
    end else begin
      stg_q[0] <= '{vld: upd, val: val};
      for (int i = 1; i < NSTG; i++) stg_q[i] <= stg_q[i-1];
      if (stg_q[NSTG-1].vld) mask_q <= stg_q[NSTG-1].val;
    end
  end
endmodule

// File: rtl/irq_move_gate.sv
module irq_move_gate (
  input  logic mv_active,
  input  logic mv_word,
  input  logic mv_break,
  output logic hold,
  output logic at_break
);
  logic byte_mv, word_mv;

  assign byte_mv  = mv_active & ~mv_word;
  assign word_mv  = mv_active & mv_word;
  assign hold     = byte_mv | (word_mv & ~mv_break);
  assign at_break = word_mv & mv_break;
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned BLACKOUT   = BLACKOUT_DEF,
  parameter int unsigned MASK_DELAY = MASK_DELAY_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_pend,
  input  logic nmi_pend,
  input  logic mask_upd,
  input  logic mask_new,
  input  logic mv_active,
  input  logic mv_word,
  input  logic mv_break,
  output logic irq_take,
  output logic irq_take_nmi,
  output logic resume_next,
  output logic mask_eff
);
  logic  blk, mv_hold, mv_brk, gate;
  take_t nxt;
  logic  take_q, nmi_q, rn_q;

  irq_blackout #(.BLACKOUT(BLACKOUT)) u_blk (
    .clk(clk), .rst(rst), .upd(mask_upd), .blocked(blk)
  );

  irq_mask_commit #(.MASK_DELAY(MASK_DELAY)) u_msk (
    .clk(clk), .rst(rst), .upd(mask_upd), .val(mask_new), .mask_q(mask_eff)
  );

  irq_move_gate u_mv (
    .mv_active(mv_active), .mv_word(mv_word), .mv_break(mv_break),
    .hold(mv_hold), .at_break(mv_brk)
  );

  assign gate = ~blk & ~mv_hold & ~take_q;

  always_comb begin
    nxt.nmi      = nmi_pend & gate;
    nxt.mskd     = irq_pend & ~mask_eff & gate;
    nxt.at_break = mv_brk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      nmi_q  <= 1'b0;
      rn_q   <= 1'b0;
    end else begin
      take_q <= nxt.nmi | nxt.mskd;
      nmi_q  <= nxt.nmi;
      rn_q   <= (nxt.nmi | nxt.mskd) & nxt.at_break;
    end
  end

  assign irq_take     = take_q;
  assign irq_take_nmi = nmi_q;
  assign resume_next  = rn_q;
endmodule

// File: rtl/irq_accept_gate_chk.sv
module irq_accept_gate_chk (
  input logic clk,
  input logic rst,
  input logic irq_pend,
  input logic nmi_pend,
  input logic mask_upd,
  input logic mv_active,
  input logic mv_word,
  input logic mv_break,
  input logic irq_take,
  input logic irq_take_nmi,
  input logic resume_next,
  input logic mask_eff
);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  a_r2_has_request: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> $past(irq_pend || nmi_pend));

  a_r3_no_take_after_upd: assert property (@(posedge clk) disable iff (rst)
    mask_upd |=> !irq_take);

  a_r5_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(mask_upd) && !$past(mask_upd, 2)) |-> $stable(mask_eff));

  a_r6_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !irq_take_nmi) |-> !$past(mask_eff));

  a_r7_byte_move: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !$past(mv_active && !mv_word));

  a_r8_word_break: assert property (@(posedge clk) disable iff (rst)
    (irq_take && $past(mv_active && mv_word)) |-> ($past(mv_break) && resume_next));

  a_r8_no_stray_resume: assert property (@(posedge clk) disable iff (rst)
    resume_next |-> irq_take);

  a_r9_nmi_source: assert property (@(posedge clk) disable iff (rst)
    irq_take_nmi |-> (irq_take && $past(nmi_pend)));
endmodule

bind irq_accept_gate irq_accept_gate_chk i_chk (
  .clk(clk), .rst(rst), .irq_pend(irq_pend), .nmi_pend(nmi_pend),
  .mask_upd(mask_upd), .mv_active(mv_active), .mv_word(mv_word),
  .mv_break(mv_break), .irq_take(irq_take), .irq_take_nmi(irq_take_nmi),
  .resume_next(resume_next), .mask_eff(mask_eff)
);

// File: tb/test_irq_accept_gate.sv
`timescale 1ns/1ps
module test_irq_accept_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_pend = 0, nmi_pend = 0, mask_upd = 0, mask_new = 0;
  logic mv_active = 0, mv_word = 0, mv_break = 0;
  logic irq_take, irq_take_nmi, resume_next, mask_eff;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state, computed from the requirements
  int   m_cnt;
  logic m_pv, m_pd, m_mask, m_take, m_nmi, m_rn;

  always #2.5 clk = ~clk;

  irq_accept_gate i_irq_accept_gate (.*);

  task automatic chk(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic string why();
    if (mask_upd || m_cnt != 0) return (m_cnt != 0 && mask_upd) ? "R4" : "R3";
    if (mv_active && !mv_word) return "R7";
    if (mv_active && mv_word) return "R8";
    if (nmi_pend && irq_pend) return "R9";
    if (irq_pend && m_mask) return "R6";
    return tag;
  endfunction

  // advance the model over the coming edge using the present inputs
  task automatic model_step();
    logic blk, hold, g, en, em;
    blk  = mask_upd || (m_cnt != 0);
    hold = mv_active && !(mv_word && mv_break);
    g    = !blk && !hold && !m_take;
    en   = nmi_pend && g;
    em   = irq_pend && !m_mask && g;
    m_take = en || em;
    m_nmi  = en;
    m_rn   = (en || em) && mv_active && mv_word && mv_break;
    if (m_pv) m_mask = m_pd;
    m_pv = mask_upd; m_pd = mask_new;
    if (mask_upd) m_cnt = 2; else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic compare(string t);
    chk(t, "irq_take", irq_take, m_take);
    chk(t, "irq_take_nmi", irq_take_nmi, m_nmi);
    chk(t, "resume_next", resume_next, m_rn);
    chk(t == "R5" ? "R5" : t, "mask_eff", mask_eff, m_mask);
  endtask

  // one cycle: inputs already set at negedge; run edge; check at next negedge
  task automatic cyc();
    string t;
    t = why();
    model_step();
    @(negedge clk);
    compare(t);
    mask_upd = 0;
    mv_break = 0;
    if (irq_take && !irq_take_nmi) irq_pend = 0;
    if (irq_take_nmi) nmi_pend = 0;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_pv = 0; m_pd = 0; m_mask = 1; m_take = 0; m_nmi = 0; m_rn = 0;
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", "irq_take in reset", irq_take, 1'b0);
    chk("R1", "mask_eff in reset", mask_eff, 1'b1);
    rst = 0;
    // R1: NMI right after reset, no blackout pending
    tag = "R1"; nmi_pend = 1; cyc(); cyc();
    // R6: maskable request with mask set is never taken
    tag = "R6"; irq_pend = 1; repeat (4) cyc();
    // R5: clear the mask; R3 window keeps it off
    tag = "R5"; mask_upd = 1; mask_new = 0; cyc(); repeat (5) cyc();
    // R4: back-to-back updates restart the window
    irq_pend = 1; mask_upd = 1; mask_new = 0; cyc();
    mask_upd = 1; cyc(); repeat (5) cyc();
    // R7: byte move blocks NMI
    tag = "R7"; mv_active = 1; mv_word = 0; nmi_pend = 1; repeat (5) cyc();
    mv_active = 0; repeat (3) cyc();
    // R8: word move, take only at a break
    tag = "R8"; mv_active = 1; mv_word = 1; irq_pend = 1; repeat (3) cyc();
    mv_break = 1; cyc(); repeat (2) cyc();
    mv_active = 0; cyc();
    // R9: both requests in one cycle
    tag = "R9"; irq_pend = 1; nmi_pend = 1; repeat (4) cyc();
    // R2: random mix
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      if (!irq_pend) irq_pend = ($urandom % 4) == 0;
      if (!nmi_pend) nmi_pend = ($urandom % 12) == 0;
      mask_upd = ($urandom % 6) == 0;
      mask_new = $urandom % 2;
      if (($urandom % 16) == 0) begin
        mv_active = !mv_active;
        mv_word = $urandom % 2;
      end
      mv_break = mv_active && mv_word && (($urandom % 3) == 0);
      cyc();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule